// File: doc/BRIEF.md
# Supply-Fault Interrupt Controller

This block raises a level interrupt toward the host when a 32-bit digital output peripheral reports a supply-voltage fault or a short-circuit (overcurrent) fault. Each fault input is asynchronous. It passes through a synchroniser, and its rising edge is recorded in a per-source status bit. A status bit can set only while that source is enabled. The host reads the status word to see which fault occurred. It then acknowledges by writing zero to the enable bits of the sources it has handled. That write clears the matching status bits and drops the request.

Software reaches the block through a 32-bit register channel addressed in words. A command carries a write flag, a word address and write data, and it is accepted when `cmd_valid_i` and `cmd_ready_o` are both high. A read returns its data on a response channel one cycle after acceptance. The response is held, with `rsp_rdata_o` unchanged, until `rsp_ready_i` is high. While a response waits, `cmd_ready_o` is low, which is the block's only form of back-pressure. Writes produce no response.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset the enable bits and the status bits are zero and `irq_o` is low. Reads of words 1, 2 and 3 return zero.
- R2: Word 1 (byte offset 0x04) is the enable register. Bit 0 enables the supply-voltage source and bit 1 enables the short-circuit source. Both bits read back as written, and bits 31:2 read as zero whatever was written.
- R3: A rising edge on `fault_vcc_i` while enable bit 0 is set sets status bit 0 in word 2 (byte offset 0x08). The bit is visible three clock edges after the input changes.
- R4: A rising edge on `fault_sc_i` while enable bit 1 is set sets status bit 1 in word 2. The bit is visible three clock edges after the input changes.
- R5: A fault edge on a disabled source sets no status bit. A fault level that stays high sets nothing again after its bit has been cleared, because only edges are recorded.
- R6: Writing word 1 with bit N equal to zero clears status bit N in the cycle of the write. Status bits of sources written with one are kept. A status bit therefore never stays set while its enable bit is zero.
- R7: `irq_o` is high exactly when some status bit and its enable bit are both set. Bit 0 of word 3 (byte offset 0x0C) reads the same value, and bits 31:1 of word 3 read as zero.
- R8: Words other than 1, 2 and 3 read as zero. Writes to them, and writes to words 2 and 3, change no state.
- R9: A read response stays valid with unchanged data until `rsp_ready_i` is high, and `cmd_ready_o` is low for as long as a response is waiting.
- R10: An accepted read raises `rsp_valid_o` on the next clock edge. The data returned are the register values as they stood at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_vcc_i | input | 1 | Asynchronous supply-voltage fault level |
| fault_sc_i | input | 1 | Asynchronous short-circuit fault level |
| cmd_valid_i | input | 1 | Register command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W (4) | Word address (byte offset / 4) |
| cmd_wdata_i | input | DATA_W (32) | Write data |
| rsp_valid_o | output | 1 | Read data present |
| rsp_ready_i | input | 1 | Requester takes read data |
| rsp_rdata_o | output | DATA_W (32) | Read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that each fault input holds every level for at least SYNC_STAGES+1 clock cycles, so that every change appears as exactly one synchronised edge. They also assume that a requester keeps a command stable until it is accepted. The bench changes the fault inputs only on falling clock edges and holds each level for four or more cycles. It issues one command at a time and waits for each read response before the next command. Back-pressure is covered by withholding `rsp_ready_i` for several cycles while a read response is pending.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  localparam int NUM_SRC  = 2;
  localparam int SRC_VCC  = 0;
  localparam int SRC_SC   = 1;
  localparam int WORD_ENABLE  = 1;
  localparam int WORD_STATUS  = 2;
  localparam int WORD_SUMMARY = 3;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_STATUS,
    SEL_SUMMARY
  } reg_sel_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o
);
  for (genvar s = 0; s < N; s++) begin : g_src
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        if (STAGES > 1) chain_q <= {chain_q[STAGES-2:0], raw_i[s]};
        else            chain_q <= raw_i[s];
        prev_q <= chain_q[STAGES-1];
      end
    end

    assign rise_o[s] = chain_q[STAGES-1] & ~prev_q;

    AST_EDGE_IS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[s] |=> !rise_o[s]) else $error("double edge"); // R5
  end
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] status_o
);
  logic [N-1:0] enable_q, status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable_q <= '0;
    else if (en_wr_i) enable_q <= en_wdata_i;
  end

  for (genvar s = 0; s < N; s++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             status_q[s] <= 1'b0;
      else if (en_wr_i && !en_wdata_i[s])     status_q[s] <= 1'b0;
      else if (rise_i[s] && enable_q[s])      status_q[s] <= 1'b1;
    end

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[s]) |-> $past(rise_i[s] && enable_q[s])) else $error("spurious set"); // R5
    AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr_i && !en_wdata_i[s]) |=> !status_q[s]) else $error("no clear"); // R6
  end

  AST_NO_STATUS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~enable_q) == '0) else $error("status while disabled"); // R6

  assign enable_o = enable_q;
  assign status_o = status_q;
endmodule

// File: rtl/fault_regbus.sv
module fault_regbus
  import fault_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [N-1:0]      enable_i,
  input  logic [N-1:0]      status_i,
  input  logic              pending_i,
  output logic              en_wr_o,
  output logic [N-1:0]      en_wdata_o
);
  reg_sel_e          sel;
  logic              accept;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q, rd_mux;
  logic              unused_wbits;

  always_comb begin
    if (cmd_addr_i == ADDR_W'(WORD_ENABLE))       sel = SEL_ENABLE;
    else if (cmd_addr_i == ADDR_W'(WORD_STATUS))  sel = SEL_STATUS;
    else if (cmd_addr_i == ADDR_W'(WORD_SUMMARY)) sel = SEL_SUMMARY;
    else                                          sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_ENABLE:  rd_mux = DATA_W'(enable_i);
      SEL_STATUS:  rd_mux = DATA_W'(status_i);
      SEL_SUMMARY: rd_mux = DATA_W'(pending_i);
      default:     rd_mux = '0;
    endcase
  end

  assign cmd_ready_o  = !rsp_valid_q;
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign en_wr_o      = accept && cmd_write_i && (sel == SEL_ENABLE);
  assign en_wdata_o   = cmd_wdata_i[N-1:0];
  assign unused_wbits = ^cmd_wdata_i[DATA_W-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !cmd_write_i) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_valid_q && rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o) else $error("response dropped"); // R9
  AST_RSP_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> $stable(rsp_rdata_o)) else $error("data moved"); // R9
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && !cmd_write_i) |=> rsp_valid_o) else $error("no response"); // R10
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_vcc_i,
  input  logic              fault_sc_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] raw, rise, enable, status, en_wdata;
  logic               en_wr, pending;

  assign raw[SRC_VCC] = fault_vcc_i;
  assign raw[SRC_SC]  = fault_sc_i;

  fault_sync #(.STAGES(SYNC_STAGES), .N(NUM_SRC)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .rise_o(rise));

  fault_latch #(.N(NUM_SRC)) latch_i (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .rise_i(rise), .enable_o(enable), .status_o(status));

  assign pending = |(status & enable);
  assign irq_o   = pending;

  fault_regbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NUM_SRC)) bus_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_write_i(cmd_write_i), .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o),
    .enable_i(enable), .status_i(status), .pending_i(pending),
    .en_wr_o(en_wr), .en_wdata_o(en_wdata));

  AST_IRQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(en_wr)) else $error("irq fell without ack"); // R6
  AST_IRQ_RISES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|rise)) else $error("irq rose without edge"); // R7
endmodule

// File: tb/fault_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fault_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_vcc = 1'b0, fault_sc = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b0;
  logic [3:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  fault_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fault_vcc_i(fault_vcc), .fault_sc_i(fault_sc),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", 32'(irq), 0);
    rd(4'd1, d); chk("R1 enable reset", d, 0);
    rd(4'd2, d); chk("R1 status reset", d, 0);
    rd(4'd3, d); chk("R1 summary reset", d, 0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); chk("R2 enable all ones", d, 32'h3);
    wr(4'd1, 32'h0000_0001); rd(4'd1, d); chk("R2 enable vcc only", d, 32'h1);
  endtask

  task automatic t_vcc_fault();
    logic [31:0] d;
    fault_vcc = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R3 not yet after two edges", 32'(irq), 0);
    @(negedge clk); chk("R3 irq after third edge", 32'(irq), 1);
    rd(4'd2, d); chk("R3 status vcc", d, 32'h1);
    rd(4'd3, d); chk("R7 summary high", d, 32'h1);
    fault_vcc = 1'b0; wait_cyc(4);
  endtask

  task automatic t_disabled_source();
    logic [31:0] d;
    fault_sc = 1'b1; wait_cyc(5);
    rd(4'd2, d); chk("R5 disabled sc not latched", d, 32'h1);
    fault_sc = 1'b0; wait_cyc(4);
  endtask

  task automatic t_ack_all();
    logic [31:0] d;
    wr(4'd1, 32'h0);
    chk("R6 irq cleared by ack", 32'(irq), 0);
    rd(4'd2, d); chk("R6 status cleared", d, 0);
    rd(4'd3, d); chk("R7 summary low", d, 0);
  endtask

  task automatic t_both_partial_ack();
    logic [31:0] d;
    wr(4'd1, 32'h3);
    fault_vcc = 1'b1; fault_sc = 1'b1; wait_cyc(5);
    rd(4'd2, d); chk("R4 both status bits", d, 32'h3);
    wr(4'd2, 32'h0); wr(4'd3, 32'h0);
    rd(4'd2, d); chk("R8 status write ignored", d, 32'h3);
    wr(4'd1, 32'h2);
    rd(4'd2, d); chk("R6 partial ack keeps sc", d, 32'h2);
    chk("R7 irq still high", 32'(irq), 1);
    wr(4'd1, 32'h0);
    chk("R6 irq low after full ack", 32'(irq), 0);
  endtask

  task automatic t_level_held();
    logic [31:0] d;
    wr(4'd1, 32'h3); wait_cyc(6);
    rd(4'd2, d); chk("R5 held level not re-latched", d, 0);
    chk("R7 irq low with no status", 32'(irq), 0);
    fault_vcc = 1'b0; fault_sc = 1'b0; wait_cyc(4);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd0, d);  chk("R8 word 0 reads zero", d, 0);
    rd(4'd4, d);  chk("R8 word 4 reads zero", d, 0);
    rd(4'd15, d); chk("R8 word 15 reads zero", d, 0);
    rd(4'd1, d);  chk("R8 enable untouched", d, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d0;
    wr(4'd1, 32'h2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 4'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 response one cycle after accept", 32'(rsp_valid), 1);
    d0 = rsp_rdata;
    chk("R10 read data", d0, 32'h2);
    wr(4'd1, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 response held", 32'(rsp_valid), 1);
      chk("R9 data stable", rsp_rdata, d0);
      chk("R9 cmd_ready low while waiting", 32'(cmd_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 response consumed", 32'(rsp_valid), 0);
    rd(4'd1, d0); chk("R9 write blocked while busy", d0, 32'h2);
    wr(4'd1, 32'h0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_enable_rw();
    t_vcc_fault();
    t_disabled_source();
    t_ack_all();
    t_both_partial_ack();
    t_level_held();
    t_unused();
    t_backpressure();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired before the last scenario");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule